// File: doc/BRIEF.md
# Dual-Class Priority Interrupt Arbiter

This block picks one winning interrupt line for each of two request classes: a normal class and a fast class. There are up to three banks of 32 lines. Each line brings four things: a pending bit, a mask bit, a class-select bit and a priority value. In every cycle the block scans all lines and registers the best eligible line for each class. A class holds a one-shot grant token. While the token is held and an eligible line exists, the block latches the line number and raises that class's request output towards the processor. Latching the winner uses up the token.

The interrupt handler reads the latched line number. It then returns the token with a re-arm pulse. The pulse drops the request, and the next evaluation follows from the lines pending at that time. A global mask input stops any new winner from being latched while it is high.

Top module: `prio_intr_arbiter`

## Requirements
- R1: After reset both tokens are held, both latched codes read 0 and both request outputs are low.
- R2: A line is eligible for a class only if it is pending, its mask bit is 0, and its class-select bit matches the class (1 selects the fast class, 0 the normal class).
- R3: Among eligible lines, the one with the numerically lowest priority value wins; priority 0 is the most urgent.
- R4: When eligible lines share the best priority, the line with the highest index across all banks wins. Line n is bit n of the line vectors, and bank b holds lines 32b to 32b+31.
- R5: A winner is latched and the class request goes high only at an edge where the class holds its token, an eligible line exists and the global mask is low. When the global mask is high at an edge, the code is unchanged after that edge.
- R6: Latching a winner releases the class token. Until the next re-arm, the code and the request do not change, whatever lines arrive.
- R7: A re-arm pulse for a class drives its request low and restores its token at the next edge. No winner is latched at that edge.
- R8: Lines in banks at or above the NUM_BANKS parameter are never eligible.
- R9: The search result is registered. A line condition present at edge t can be latched at edge t+1 at the earliest.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pend_i | input | 96 | Pending bit per line |
| mask_i | input | 96 | Mask bit per line (1 blocks) |
| steer_i | input | 96 | Class select per line (1 = fast class) |
| prio_i | input | 96*PRIO_W | Priority per line; line n in bits [n*PRIO_W +: PRIO_W] |
| gmask_i | input | 1 | Global mask, blocks latching while high |
| rearm_irq_i | input | 1 | Re-arm pulse for the normal class |
| rearm_fiq_i | input | 1 | Re-arm pulse for the fast class |
| irq_code_o | output | 7 | Latched winner, normal class |
| irq_req_o | output | 1 | Request, normal class |
| fiq_code_o | output | 7 | Latched winner, fast class |
| fiq_req_o | output | 1 | Request, fast class |

## Verification
A tie between line 5 and line 70 at equal priority separates a highest-index winner from a lowest-index one. The same stimulus, applied to an instance with one bank, separates that from a design that ignores bank presence. A more urgent low line set against a less urgent high line separates priority ordering from index ordering. Masked lines, lines steered to the other class, a global-mask window and lines that arrive after a latch probe eligibility and the token. Long runs of random patterns with a narrow priority range force frequent ties and random re-arm timing, and a cycle-level model checks both classes on every clock.

// File: rtl/intc_arb_pkg.sv
package intc_arb_pkg;
    localparam int MAX_BANKS  = 3;
    localparam int BANK_LINES = 32;
    localparam int MAX_LINES  = MAX_BANKS * BANK_LINES;
    localparam int IDX_W      = $clog2(MAX_LINES);

    typedef struct packed {
        logic             found;
        logic [IDX_W-1:0] idx;
    } search_t;

    typedef struct packed {
        logic             agree;
        logic             req;
        logic [IDX_W-1:0] code;
    } class_st_t;
endpackage

// File: rtl/prio_search.sv
module prio_search
    import intc_arb_pkg::*;
#(
    parameter int NUM_BANKS = 3,
    parameter int PRIO_W    = 6,
    parameter bit FIQ_CLASS = 1'b0
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [MAX_LINES-1:0]          pend_i,
    input  logic [MAX_LINES-1:0]          mask_i,
    input  logic [MAX_LINES-1:0]          steer_i,
    input  logic [MAX_LINES*PRIO_W-1:0]   prio_i,
    output search_t                       res_o
);
    localparam int ACTIVE = NUM_BANKS * BANK_LINES;

    logic [MAX_LINES-1:0] present;
    logic [MAX_LINES-1:0] elig;

    genvar g;
    generate
        for (g = 0; g < MAX_LINES; g++) begin : g_line
            if (g < ACTIVE) begin : g_on
                assign present[g] = 1'b1;
            end else begin : g_off
                assign present[g] = 1'b0;
            end
            assign elig[g] = present[g] & pend_i[g] & ~mask_i[g] & (steer_i[g] == FIQ_CLASS);
        end
    endgenerate

    search_t             res_d, res_q;
    logic [PRIO_W-1:0]   best_p;

    // Ascending scan with <= keeps the highest index on a priority tie.
    always_comb begin
        res_d  = '0;
        best_p = '1;
        for (int i = 0; i < MAX_LINES; i++) begin
            if (elig[i] && (!res_d.found || prio_i[i*PRIO_W +: PRIO_W] <= best_p)) begin
                res_d.found = 1'b1;
                res_d.idx   = IDX_W'(i);
                best_p      = prio_i[i*PRIO_W +: PRIO_W];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= res_d;
    end

    assign res_o = res_q;

    assert_absent_bank_R8: assert property (@(posedge clk) disable iff (!rst_n)
        res_q.found |-> (int'(res_q.idx) < ACTIVE));
endmodule

// File: rtl/class_ctrl.sv
module class_ctrl
    import intc_arb_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  search_t          res_i,
    input  logic             gmask_i,
    input  logic             rearm_i,
    output logic [IDX_W-1:0] code_o,
    output logic             req_o
);
    class_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rearm_i) begin
            st_d.req   = 1'b0;
            st_d.agree = 1'b1;
        end else if (st_q.agree && res_i.found && !gmask_i) begin
            st_d.code  = res_i.idx;
            st_d.req   = 1'b1;
            st_d.agree = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.agree <= 1'b1;
            st_q.req   <= 1'b0;
            st_q.code  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign code_o = st_q.code;
    assign req_o  = st_q.req;

    assert_gmask_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        gmask_i |=> $stable(st_q.code));
    assert_code_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.agree |=> $stable(st_q.code));
    assert_token_spent_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.req) |-> !st_q.agree);
    assert_rearm_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rearm_i |=> (!st_q.req && st_q.agree));
endmodule

// File: rtl/prio_intr_arbiter.sv
module prio_intr_arbiter
    import intc_arb_pkg::*;
#(
    parameter int NUM_BANKS = 3,
    parameter int PRIO_W    = 6
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [MAX_LINES-1:0]        pend_i,
    input  logic [MAX_LINES-1:0]        mask_i,
    input  logic [MAX_LINES-1:0]        steer_i,
    input  logic [MAX_LINES*PRIO_W-1:0] prio_i,
    input  logic                        gmask_i,
    input  logic                        rearm_irq_i,
    input  logic                        rearm_fiq_i,
    output logic [IDX_W-1:0]            irq_code_o,
    output logic                        irq_req_o,
    output logic [IDX_W-1:0]            fiq_code_o,
    output logic                        fiq_req_o
);
    search_t           res   [2];
    logic              rearm [2];
    logic [IDX_W-1:0]  code  [2];
    logic              req   [2];

    assign rearm[0] = rearm_irq_i;
    assign rearm[1] = rearm_fiq_i;

    genvar c;
    generate
        for (c = 0; c < 2; c++) begin : g_class
            prio_search #(
                .NUM_BANKS (NUM_BANKS),
                .PRIO_W    (PRIO_W),
                .FIQ_CLASS (c == 1)
            ) u_search (
                .clk     (clk),
                .rst_n   (rst_n),
                .pend_i  (pend_i),
                .mask_i  (mask_i),
                .steer_i (steer_i),
                .prio_i  (prio_i),
                .res_o   (res[c])
            );
            class_ctrl u_ctrl (
                .clk     (clk),
                .rst_n   (rst_n),
                .res_i   (res[c]),
                .gmask_i (gmask_i),
                .rearm_i (rearm[c]),
                .code_o  (code[c]),
                .req_o   (req[c])
            );
        end
    endgenerate

    assign irq_code_o = code[0];
    assign irq_req_o  = req[0];
    assign fiq_code_o = code[1];
    assign fiq_req_o  = req[1];
endmodule

// File: tb/prio_intr_arbiter_tb.sv
module prio_intr_arbiter_tb;
    localparam int L = 96;
    localparam int PW = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [L-1:0] pend = '0, mask = '0, steer = '0;
    logic [L*PW-1:0] prio_v = '0;
    logic gmask = 1'b0, rearm_irq = 1'b0, rearm_fiq = 1'b0;

    logic [6:0] a_icode, a_fcode, b_icode, b_fcode;
    logic a_ireq, a_freq, b_ireq, b_freq;

    always #10 clk = ~clk;

    prio_intr_arbiter #(.NUM_BANKS(3), .PRIO_W(PW)) u_dut (
        .clk(clk), .rst_n(rst_n), .pend_i(pend), .mask_i(mask), .steer_i(steer),
        .prio_i(prio_v), .gmask_i(gmask), .rearm_irq_i(rearm_irq), .rearm_fiq_i(rearm_fiq),
        .irq_code_o(a_icode), .irq_req_o(a_ireq), .fiq_code_o(a_fcode), .fiq_req_o(a_freq));

    prio_intr_arbiter #(.NUM_BANKS(1), .PRIO_W(PW)) u_dut_b1 (
        .clk(clk), .rst_n(rst_n), .pend_i(pend), .mask_i(mask), .steer_i(steer),
        .prio_i(prio_v), .gmask_i(gmask), .rearm_irq_i(rearm_irq), .rearm_fiq_i(rearm_fiq),
        .irq_code_o(b_icode), .irq_req_o(b_ireq), .fiq_code_o(b_fcode), .fiq_req_o(b_freq));

    int vectors = 0;
    int fails = 0;
    string tag = "R1";

    // model state indexed [instance][class]
    bit m_found [2][2];
    int m_idx   [2][2];
    bit m_agree [2][2];
    bit m_req   [2][2];
    int m_code  [2][2];

    function automatic void scan(input int nb, input int cls, output bit f, output int ix);
        int best;
        f = 0; ix = 0; best = 1 << PW;
        for (int i = nb*32 - 1; i >= 0; i--) begin
            if (pend[i] && !mask[i] && (int'(steer[i]) == cls)) begin
                if (int'(prio_v[i*PW +: PW]) < best) begin
                    best = int'(prio_v[i*PW +: PW]);
                    f = 1; ix = i;
                end
            end
        end
    endfunction

    task automatic model_reset();
        for (int k = 0; k < 2; k++)
            for (int c = 0; c < 2; c++) begin
                m_found[k][c] = 0; m_idx[k][c] = 0;
                m_agree[k][c] = 1; m_req[k][c] = 0; m_code[k][c] = 0;
            end
    endtask

    task automatic model_clock();
        for (int k = 0; k < 2; k++)
            for (int c = 0; c < 2; c++) begin
                bit ra;
                ra = (c == 0) ? rearm_irq : rearm_fiq;
                if (ra) begin
                    m_req[k][c] = 0; m_agree[k][c] = 1;
                end else if (m_agree[k][c] && m_found[k][c] && !gmask) begin
                    m_code[k][c] = m_idx[k][c]; m_req[k][c] = 1; m_agree[k][c] = 0;
                end
                scan((k == 0) ? 3 : 1, c, m_found[k][c], m_idx[k][c]);
            end
    endtask

    task automatic chk(input string what, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic compare_all();
        chk("A irq_req",  int'(a_ireq),  int'(m_req[0][0]));
        chk("A irq_code", int'(a_icode), m_code[0][0]);
        chk("A fiq_req",  int'(a_freq),  int'(m_req[0][1]));
        chk("A fiq_code", int'(a_fcode), m_code[0][1]);
        chk("B irq_req",  int'(b_ireq),  int'(m_req[1][0]));
        chk("B irq_code", int'(b_icode), m_code[1][0]);
        chk("B fiq_req",  int'(b_freq),  int'(m_req[1][1]));
        chk("B fiq_code", int'(b_fcode), m_code[1][1]);
    endtask

    task automatic step();
        @(posedge clk);
        if (rst_n) model_clock(); else model_reset();
        @(negedge clk);
        compare_all();
    endtask

    task automatic clear_lines();
        pend = '0; mask = '0; steer = '0; prio_v = '0;
    endtask

    task automatic rearm_both();
        rearm_irq = 1; rearm_fiq = 1; step();
        rearm_irq = 0; rearm_fiq = 0;
    endtask

    initial begin
        #(20 * 200000);
        fails++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        model_reset();
        // R1: reset state
        tag = "R1";
        step(); step();
        chk("reset agree-driven req", int'(a_ireq | a_freq), 0);
        @(negedge clk); rst_n = 1;
        step(); step();

        // R4: tie between line 5 and line 70
        tag = "R4";
        prio_v[5*PW +: PW] = 3; prio_v[70*PW +: PW] = 3;
        pend[5] = 1; pend[70] = 1;
        step(); step(); step();
        chk("tie winner A", int'(a_icode), 70);
        chk("tie winner B (one bank)", int'(b_icode), 5);

        // R6: more urgent arrival after latch does not change code
        tag = "R6";
        pend[40] = 1; prio_v[40*PW +: PW] = 0;
        step(); step(); step();
        chk("frozen code", int'(a_icode), 70);

        // R7: re-arm then re-evaluate
        tag = "R7";
        rearm_irq = 1; step(); rearm_irq = 0;
        chk("req low after rearm", int'(a_ireq), 0);
        step();
        chk("relatch line 40", int'(a_icode), 40);

        // R8: only bank-1 line pending, one-bank instance must not latch
        tag = "R8";
        clear_lines(); rearm_both();
        pend[40] = 1; step(); step(); step();
        chk("one-bank instance no req", int'(b_ireq), 0);

        // R3: urgency beats index
        tag = "R3";
        clear_lines(); rearm_both();
        pend[10] = 1; prio_v[10*PW +: PW] = 1;
        pend[80] = 1; prio_v[80*PW +: PW] = 7;
        step(); step(); step();
        chk("lower value wins", int'(a_icode), 10);

        // R2: masking and class steering
        tag = "R2";
        clear_lines(); rearm_both();
        pend[20] = 1; steer[20] = 1; prio_v[20*PW +: PW] = 9;
        pend[21] = 1; mask[21] = 1;
        pend[22] = 1; prio_v[22*PW +: PW] = 9;
        step(); step(); step();
        chk("fiq winner", int'(a_fcode), 20);
        chk("irq winner", int'(a_icode), 22);

        // R5: global mask blocks latching
        tag = "R5";
        clear_lines(); gmask = 1; rearm_both();
        pend[33] = 1; step(); step(); step();
        chk("blocked req", int'(a_ireq), 0);
        gmask = 0; step();

        // R9: latency, inputs at edge t latch at edge t+1
        tag = "R9";
        clear_lines(); rearm_both(); step();
        pend[12] = 1; steer[12] = 1; step();
        chk("no latch first edge", int'(a_freq), 0);
        step();
        chk("latched second edge", int'(a_freq), 1);

        // Random patterns with narrow priority range
        tag = "R3";
        for (int n = 0; n < 4000; n++) begin
            for (int i = 0; i < L; i++) begin
                pend[i]  = ($urandom_range(0, 7) == 0);
                mask[i]  = ($urandom_range(0, 3) == 0);
                steer[i] = $urandom_range(0, 1);
                prio_v[i*PW +: PW] = PW'($urandom_range(0, 3));
            end
            gmask     = ($urandom_range(0, 9) == 0);
            rearm_irq = ($urandom_range(0, 3) == 0);
            rearm_fiq = ($urandom_range(0, 3) == 0);
            step();
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule